// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital sequencer of an N-bit successive approximation converter. A start request loads a trial code with only the most significant bit set. This code drives an external N-bit DAC. The analog comparator outside the block returns one bit saying whether the held input lies at or above the DAC level. Each clock, the controller settles the bit under trial from that bit. It keeps the bit when the comparator reports "at or above" and clears it otherwise. It then moves the trial to the next lower bit, until the least significant bit is decided.

A one-hot pointer register marks the bit under trial, and a trial register holds the code. After the last decision the controller raises end-of-conversion. It publishes the N-bit result and holds both until the next start. The sample-and-hold, the DAC and the comparator are outside the block.

Top module: `sar_ctrl`

## Requirements
- R1: A synchronous active-high reset, at any time including mid-conversion, drives busy, done, the DAC code and the result to zero at the next clock edge.
- R2: A start sampled while no conversion runs makes busy high at the next edge and sets the DAC code to the half-scale trial, which has only bit N-1 set.
- R3: In each decision cycle the bit under trial becomes the comparator input (1 = input at or above DAC level, keep; 0 = below, clear). Bits above it are unchanged, and the next lower bit is set as the new trial.
- R4: Bits are decided from MSB to LSB, one per clock. Done rises exactly N+1 clock edges after the start edge: one load edge, then N decision edges. Done stays low before that.
- R5: With an ideal comparator, the result equals the held input code for every code from 0 to 2^N-1.
- R6: While no start arrives, done stays high and the result and DAC code stay unchanged, even when the analog input changes.
- R7: A start asserted while busy is ignored. The running conversion keeps its schedule and its result.
- R8: A start sampled while done is high clears done at the next edge and begins a new conversion at once.
- R9: Busy and done are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Conversion request |
| cmp_above_i | input | 1 | Comparator result, 1 when input is at or above the DAC level |
| dac_code_o | output | WIDTH | Trial code to the DAC, taken from a register |
| result_o | output | WIDTH | Converted code, valid while done_o is high |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | End of conversion |

## Verification
A misplaced trial pointer or a wrongly latched comparator bit shows on dac_code_o in the very next cycle. The bench traces that code after every decision edge against the input's leading bits. A sequencer fault that ends early or late moves the done edge off its fixed N+1 count, and this is caught on the cycle it happens. A lost or misordered decision gives a wrong final code, and the full sweep of every input value exposes it at the end of that conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_DONE = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic last_i,
  output logic load_o,
  output logic decide_o,
  output logic busy_o,
  output logic done_o
);
  sar_state_e state_q, state_d;

  // a start only counts outside a running conversion
  assign load_o   = start_i && (state_q != ST_CONV);
  assign decide_o = (state_q == ST_CONV);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start_i) state_d = ST_CONV;
      ST_CONV:          if (last_i)  state_d = ST_DONE;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign busy_o = (state_q == ST_CONV);
  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/sar_pointer.sv
module sar_pointer #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             shift_i,
  output logic [WIDTH-1:0] ptr_o
);
  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst)          ptr_q <= '0;
    else if (load_i)  ptr_q <= TOP_BIT;
    else if (shift_i) ptr_q <= ptr_q >> 1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/sar_latch.sv
module sar_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             decide_i,
  input  logic [WIDTH-1:0] ptr_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] trial_o,
  output logic [WIDTH-1:0] result_o
);
  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] trial_q, trial_d, result_q;

  // per bit: settle the bit under trial, raise the bit just below it
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic below_trial;
    if (i == WIDTH-1) begin : g_msb
      assign below_trial = 1'b0;
    end else begin : g_rest
      assign below_trial = ptr_i[i+1];
    end
    assign trial_d[i] = ptr_i[i]    ? cmp_i :
                        below_trial ? 1'b1  : trial_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst)           trial_q <= '0;
    else if (load_i)   trial_q <= TOP_BIT;
    else if (decide_i) trial_q <= trial_d;
  end

  always_ff @(posedge clk) begin
    if (rst)                       result_q <= '0;
    else if (decide_i && ptr_i[0]) result_q <= trial_d;
  end

  assign trial_o  = trial_q;
  assign result_o = result_q;
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             cmp_above_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic [WIDTH-1:0] result_o,
  output logic             busy_o,
  output logic             done_o
);
  logic             load, decide;
  logic [WIDTH-1:0] trial_ptr;

  sar_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .last_i   (trial_ptr[0]),
    .load_o   (load),
    .decide_o (decide),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  sar_pointer #(.WIDTH(WIDTH)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load),
    .shift_i (decide),
    .ptr_o   (trial_ptr)
  );

  sar_latch #(.WIDTH(WIDTH)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load),
    .decide_i (decide),
    .ptr_i    (trial_ptr),
    .cmp_i    (cmp_above_i),
    .trial_o  (dac_code_o),
    .result_o (result_o)
  );
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             cmp_above_i,
  input logic [WIDTH-1:0] dac_code_o,
  input logic [WIDTH-1:0] result_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH-1:0] trial_ptr
);
  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!busy_o && !done_o && dac_code_o == '0 && result_o == '0));

  assert_start_loads_R2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (busy_o && dac_code_o == TOP_BIT));

  assert_ptr_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(trial_ptr));

  assert_bit_follows_cmp_R3: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (((dac_code_o & $past(trial_ptr)) != '0) == $past(cmp_above_i)));

  assert_ptr_walks_down_R4: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !trial_ptr[0]) |=> (busy_o && trial_ptr == ($past(trial_ptr) >> 1)));

  assert_last_ends_R4: assert property (@(posedge clk) disable iff (rst)
    (busy_o && trial_ptr[0]) |=> (done_o && !busy_o));

  assert_result_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> (done_o && $stable(result_o) && $stable(dac_code_o)));

  assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
    (done_o && start_i) |=> (!done_o && busy_o));

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));
endmodule

bind sar_ctrl sar_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .cmp_above_i (cmp_above_i),
  .dac_code_o  (dac_code_o),
  .result_o    (result_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .trial_ptr   (trial_ptr)
);

// File: tb/sar_ctrl_bench.sv
module sar_ctrl_bench;
  localparam int W  = 8;
  localparam int NV = 8;
  localparam logic [W-1:0] TAB_IN  [NV] = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h01, 8'hFE, 8'h55, 8'hAA};
  localparam logic [W-1:0] TAB_EXP [NV] = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h01, 8'hFE, 8'h55, 8'hAA};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] vin = '0;
  logic         cmp;
  logic [W-1:0] dac, res;
  logic         busy, done;
  int applied = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  // ideal comparator against the held input code
  assign cmp = (vin >= dac);

  sar_ctrl #(.WIDTH(W)) u_sar_ctrl (
    .clk (clk), .rst (rst), .start_i (start), .cmp_above_i (cmp),
    .dac_code_o (dac), .result_o (res), .busy_o (busy), .done_o (done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    applied++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int trace_exp(input int code, input int j);
    int keep = code & ~((1 << (W - j)) - 1);
    return (j < W) ? (keep | (1 << (W - 1 - j))) : keep;
  endfunction

  // b2b: caller already stands at a negedge with done high
  task automatic run_conv(input int code, input int expv, input bit trace, input bit b2b);
    if (!b2b) @(negedge clk);
    vin = code[W-1:0];
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    if (trace || b2b) begin
      chk(busy && !done, "R8 busy after start", {busy, done}, 2);
      chk(dac == (1 << (W-1)), "R2 half-scale trial", dac, 1 << (W-1));
    end
    for (int j = 1; j <= W; j++) begin
      @(posedge clk); @(negedge clk);
      if (trace) chk(dac == trace_exp(code, j), "R3 trial code", dac, trace_exp(code, j));
      if (j < W) begin
        if (trace) chk(busy && !done, "R4 still converting", {busy, done}, 2);
      end else begin
        chk(done && !busy, "R4 done after N+1 edges", {busy, done}, 1);
        chk(res == expv, "R5 result", res, expv);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && dac == 0 && res == 0, "R1 reset state", {busy, done, dac, res}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done, "R1 idle after reset", {busy, done}, 0);

    for (int v = 0; v < NV; v++) run_conv(TAB_IN[v], TAB_EXP[v], 1'b1, 1'b0);

    // R5 full sweep
    for (int c = 0; c < (1 << W); c++) run_conv(c, c, 1'b0, 1'b0);

    // R6 hold after done while input moves
    run_conv(8'h5A, 8'h5A, 1'b0, 1'b0);
    vin = 8'h13;
    repeat (10) @(negedge clk);
    chk(done && res == 8'h5A, "R6 result held", res, 8'h5A);
    chk(dac == 8'h5A, "R6 dac held", dac, 8'h5A);

    // R8 back-to-back start at the done cycle
    run_conv(8'hC3, 8'hC3, 1'b0, 1'b1);

    // R7 start while busy is ignored
    @(negedge clk);
    vin = 8'h96; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    for (int j = 1; j <= W; j++) begin
      if (j == 3 || j == 4) start = 1'b1;
      else start = 1'b0;
      @(posedge clk); @(negedge clk);
      if (j < W) chk(busy && !done, "R7 conversion undisturbed", {busy, done}, 2);
    end
    start = 1'b0;
    chk(done && res == 8'h96, "R7 result after ignored start", res, 8'h96);
    chk(dac == 8'h96, "R7 final trial code", dac, 8'h96);

    // R1 reset in the middle of a conversion
    vin = 8'h3C; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!busy && !done && dac == 0 && res == 0, "R1 reset mid-conversion", {busy, done, dac, res}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done, "R9 idle after reset", {busy, done}, 0);
    run_conv(8'h3C, 8'h3C, 1'b1, 1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL R4 watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end
endmodule